// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block sits beside a second-level cache and watches the line requests that reach it. It keeps a small table of recently touched 4 KB pages and, for each page, learns whether consecutive requests move by a constant number of lines, in either direction. Once a step size has been seen twice in a row, the block issues prefetch requests for the next lines along that stream, staying inside the page and running a bounded distance ahead of the latest observed request.

Prefetches and demand misses share one queue of outstanding line requests toward the next level. A prefetch is sent only while enough queue entries are free, never in a cycle that carries a demand allocation, and never for a line that already has an entry. The surrounding cache allocates demand misses through the demand input and returns a completion for each finished line. Both kinds of entry are freed by those completions.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset the queue is empty, no page is tracked and `pf_valid` stays low while no requests arrive.
- R2: A line address splits into a page number (all bits above the low 6) and a line offset within the 4 KB page (the low 6 bits). A page's stream is trusted only after the same nonzero offset delta is seen on two consecutive observations of that page. Differing deltas, or a single delta, produce no prefetch.
- R3: Once trusted, the block prefetches the lines last+stride, last+2·stride, up to last+4·stride in that order, at most one per cycle. Each further observation that matches the stride extends the window by one line.
- R4: No prefetch targets an offset below 0 or above 63. A stream whose next target leaves the page stops issuing.
- R5: A prefetch is issued only if at least 4 of the 16 queue entries are free before the issue. Demand allocations and prefetches each take one entry.
- R6: `pf_valid` is never high in a cycle where `dmd_alloc_valid` or `obs_valid` is high. A held-back prefetch is issued later.
- R7: A target line that already holds a queue entry is skipped without a request, and it still counts toward the 4-line window.
- R8: The table tracks 4 pages with least-recently-used replacement. An observation for an evicted page starts training from scratch.
- R9: A completion whose line matches a queued entry frees that entry, which can re-enable throttled prefetching in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_valid | input | 1 | A line request reached the cache this cycle |
| obs_line | input | LINE_W | Line address of the observed request |
| dmd_alloc_valid | input | 1 | A demand miss takes a queue entry this cycle |
| dmd_alloc_line | input | LINE_W | Line address of the demand miss |
| cmp_valid | input | 1 | A line request completed |
| cmp_line | input | LINE_W | Line address of the completed request |
| pf_valid | output | 1 | Prefetch request issued this cycle (takes a queue entry) |
| pf_line | output | LINE_W | Line address of the prefetch |

## Verification
The hardest state to reach is the throttle edge: the queue must sit at exactly the free-entry threshold while a trusted stream still has window left. The stimulus gets there by draining every outstanding line, allocating twelve demand misses, and then training a stream. Exactly one prefetch must follow. Completing a single demand line must then release exactly one more. The page-eviction case is reached by touching four fresh pages after a stream trains, so that a later access to the first page must show no prefetch until it retrains.

// File: rtl/spf_pkg.sv
package spf_pkg;
   localparam int unsigned PAGE_BYTES = 4096;
   localparam int unsigned LINE_BYTES = 64;
   localparam int unsigned OFF_W      = $clog2(PAGE_BYTES / LINE_BYTES);
   localparam int unsigned STRIDE_W   = OFF_W + 1;
   localparam int unsigned CONF_W     = 2;
   localparam logic [CONF_W-1:0] CONF_TRUST = 2'd2;

   typedef logic [OFF_W-1:0]           off_t;
   typedef logic signed [STRIDE_W-1:0] stride_t;
   typedef logic [CONF_W-1:0]          conf_t;
endpackage

// File: rtl/spf_req_queue.sv
module spf_req_queue
   import spf_pkg::*;
#(
   parameter int unsigned LINE_W   = 26,
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned MIN_FREE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dmd_valid,
   input  logic [LINE_W-1:0] dmd_line,
   input  logic              pf_valid,
   input  logic [LINE_W-1:0] pf_line,
   input  logic              cmp_valid,
   input  logic [LINE_W-1:0] cmp_line,
   input  logic [LINE_W-1:0] probe_line,
   output logic              probe_hit,
   output logic              space_ok
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned IDX_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || MIN_FREE > DEPTH) begin : g_bad_cfg
         $error("spf_req_queue: DEPTH must be >= 2 and MIN_FREE <= DEPTH");
      end
   endgenerate

   logic [DEPTH-1:0]  vld_q;
   logic [LINE_W-1:0] line_q [DEPTH];
   logic [CNT_W-1:0]  free_cnt;
   logic [IDX_W-1:0]  free_idx, cmp_idx;
   logic              have_free, cmp_hit, alloc, pf_dup;
   logic [LINE_W-1:0] alloc_line;

   always_comb begin
      free_cnt  = '0;
      free_idx  = '0;
      have_free = 1'b0;
      cmp_idx   = '0;
      cmp_hit   = 1'b0;
      probe_hit = 1'b0;
      pf_dup    = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            free_cnt  = free_cnt + CNT_W'(1);
            free_idx  = IDX_W'(i);
            have_free = 1'b1;
         end else begin
            if (line_q[i] == cmp_line) begin
               cmp_idx = IDX_W'(i);
               cmp_hit = cmp_valid;
            end
            if (line_q[i] == probe_line) probe_hit = 1'b1;
            if (line_q[i] == pf_line)    pf_dup    = 1'b1;
         end
      end
   end

   assign alloc      = dmd_valid | pf_valid;
   assign alloc_line = dmd_valid ? dmd_line : pf_line;

   generate
      if (MIN_FREE == 0) begin : g_unthrottled
         assign space_ok = have_free;
      end else begin : g_throttled
         assign space_ok = (free_cnt >= CNT_W'(MIN_FREE));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
      end else begin
         if (alloc && have_free) begin
            vld_q[free_idx]  <= 1'b1;
            line_q[free_idx] <= alloc_line;
         end
         if (cmp_hit) vld_q[cmp_idx] <= 1'b0;
      end
   end

   // R9: a demand allocation always finds a free entry
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dmd_valid |-> have_free);
   // R9: a matching completion with no allocation frees one entry
   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_hit && !alloc) |=> free_cnt == $past(free_cnt) + CNT_W'(1));
   // R5: an allocation with no completion takes one entry
   p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && have_free && !cmp_hit) |=> free_cnt == $past(free_cnt) - CNT_W'(1));
   // R7: a prefetch never duplicates a queued line
   p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> !pf_dup);
endmodule

// File: rtl/spf_stream_table.sv
module spf_stream_table
   import spf_pkg::*;
#(
   parameter int unsigned LINE_W  = 26,
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned DIST    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              obs_valid,
   input  logic [LINE_W-1:0] obs_line,
   input  logic              adv,
   output logic              cand_valid,
   output logic [LINE_W-1:0] cand_line
);
   localparam int unsigned PAGE_W = LINE_W - OFF_W;
   localparam int unsigned IDX_W  = $clog2(ENTRIES);
   localparam int unsigned AH_W   = $clog2(DIST + 1);

   generate
      if (ENTRIES < 2 || DIST < 1 || LINE_W <= OFF_W) begin : g_bad_cfg
         $error("spf_stream_table: invalid ENTRIES, DIST or LINE_W");
      end
   endgenerate

   typedef logic [PAGE_W-1:0] page_t;
   typedef logic [AH_W-1:0]   ahead_t;

   function automatic int target_of(off_t last, stride_t step, ahead_t ah);
      return int'(last) + int'(step) * (int'(ah) + 1);
   endfunction

   logic [ENTRIES-1:0] vld_q;
   page_t   page_q   [ENTRIES];
   off_t    last_q   [ENTRIES];
   stride_t stride_q [ENTRIES];
   conf_t   conf_q   [ENTRIES];
   ahead_t  ahead_q  [ENTRIES];
   logic [IDX_W-1:0] age_q [ENTRIES];

   logic [ENTRIES-1:0]            hit_vec, ok_vec;
   logic [ENTRIES-1:0][OFF_W-1:0] tgt_off;
   page_t            obs_page;
   off_t             obs_off;
   logic [IDX_W-1:0] sel, hit_idx, victim, touch;
   logic             hit_any, match;
   int               delta;

   assign obs_page = obs_line[LINE_W-1:OFF_W];
   assign obs_off  = obs_line[OFF_W-1:0];

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         int tgt;
         assign tgt        = target_of(last_q[g], stride_q[g], ahead_q[g]);
         assign tgt_off[g] = tgt[OFF_W-1:0];
         assign ok_vec[g]  = vld_q[g] && (conf_q[g] >= CONF_TRUST) &&
                             (ahead_q[g] < AH_W'(DIST)) &&
                             (tgt >= 0) && (tgt < (1 << OFF_W));
         assign hit_vec[g] = vld_q[g] && (page_q[g] == obs_page);
      end
   endgenerate

   always_comb begin
      sel        = '0;
      cand_valid = 1'b0;
      hit_idx    = '0;
      hit_any    = 1'b0;
      victim     = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (ok_vec[i]) begin
            sel        = IDX_W'(i);
            cand_valid = 1'b1;
         end
         if (hit_vec[i]) begin
            hit_idx = IDX_W'(i);
            hit_any = 1'b1;
         end
         if (age_q[i] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(i);
      end
      touch = hit_any ? hit_idx : victim;
      delta = int'(obs_off) - int'(last_q[hit_idx]);
      match = (delta == int'(stride_q[hit_idx]));
   end

   assign cand_line = {page_q[sel], tgt_off[sel]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            page_q[i]   <= '0;
            last_q[i]   <= '0;
            stride_q[i] <= '0;
            conf_q[i]   <= '0;
            ahead_q[i]  <= '0;
            age_q[i]    <= IDX_W'(i);
         end
      end else if (obs_valid) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == touch)          age_q[i] <= '0;
            else if (age_q[i] < age_q[touch]) age_q[i] <= age_q[i] + IDX_W'(1);
         end
         if (hit_any) begin
            if (delta != 0) begin
               last_q[hit_idx] <= obs_off;
               if (match) begin
                  if (conf_q[hit_idx] != '1) conf_q[hit_idx] <= conf_q[hit_idx] + CONF_W'(1);
                  if (ahead_q[hit_idx] != '0) ahead_q[hit_idx] <= ahead_q[hit_idx] - AH_W'(1);
               end else begin
                  stride_q[hit_idx] <= stride_t'(delta);
                  conf_q[hit_idx]   <= CONF_W'(1);
                  ahead_q[hit_idx]  <= '0;
               end
            end
         end else begin
            vld_q[victim]    <= 1'b1;
            page_q[victim]   <= obs_page;
            last_q[victim]   <= obs_off;
            stride_q[victim] <= '0;
            conf_q[victim]   <= '0;
            ahead_q[victim]  <= '0;
         end
      end else if (adv) begin
         ahead_q[sel] <= ahead_q[sel] + AH_W'(1);
      end
   end

   // R8: a page is tracked by at most one entry
   p_single_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      obs_valid |-> $onehot0(hit_vec));
   // R3: the window only advances on an offered candidate
   p_adv_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> cand_valid && !obs_valid);
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
   import spf_pkg::*;
#(
   parameter int unsigned LINE_W      = 26,
   parameter int unsigned Q_DEPTH     = 16,
   parameter int unsigned PF_MIN_FREE = 4,
   parameter int unsigned STREAMS     = 4,
   parameter int unsigned PF_DIST     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              obs_valid,
   input  logic [LINE_W-1:0] obs_line,
   input  logic              dmd_alloc_valid,
   input  logic [LINE_W-1:0] dmd_alloc_line,
   input  logic              cmp_valid,
   input  logic [LINE_W-1:0] cmp_line,
   output logic              pf_valid,
   output logic [LINE_W-1:0] pf_line
);
   logic              cand_valid, probe_hit, space_ok, engine_go, adv;
   logic [LINE_W-1:0] cand_line;

   spf_stream_table #(
      .LINE_W (LINE_W),
      .ENTRIES(STREAMS),
      .DIST   (PF_DIST)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .obs_valid (obs_valid),
      .obs_line  (obs_line),
      .adv       (adv),
      .cand_valid(cand_valid),
      .cand_line (cand_line)
   );

   spf_req_queue #(
      .LINE_W  (LINE_W),
      .DEPTH   (Q_DEPTH),
      .MIN_FREE(PF_MIN_FREE)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .dmd_valid (dmd_alloc_valid),
      .dmd_line  (dmd_alloc_line),
      .pf_valid  (pf_valid),
      .pf_line   (pf_line),
      .cmp_valid (cmp_valid),
      .cmp_line  (cmp_line),
      .probe_line(cand_line),
      .probe_hit (probe_hit),
      .space_ok  (space_ok)
   );

   assign engine_go = cand_valid & ~obs_valid;
   assign pf_valid  = engine_go & ~probe_hit & space_ok & ~dmd_alloc_valid;
   assign pf_line   = cand_line;
   assign adv       = engine_go & (probe_hit | (space_ok & ~dmd_alloc_valid));

   // R6: demand allocation and observation slots exclude a prefetch
   p_demand_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> !dmd_alloc_valid && !obs_valid);
endmodule

// File: tb/stream_prefetcher_tb.sv
module stream_prefetcher_tb;
   localparam int LW = 26;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          obs_valid = 1'b0, dmd_alloc_valid = 1'b0, cmp_valid = 1'b0;
   logic [LW-1:0] obs_line = '0, dmd_alloc_line = '0, cmp_line = '0;
   logic          pf_valid;
   logic [LW-1:0] pf_line;

   stream_prefetcher u_dut (
      .clk(clk), .rst_n(rst_n),
      .obs_valid(obs_valid), .obs_line(obs_line),
      .dmd_alloc_valid(dmd_alloc_valid), .dmd_alloc_line(dmd_alloc_line),
      .cmp_valid(cmp_valid), .cmp_line(cmp_line),
      .pf_valid(pf_valid), .pf_line(pf_line)
   );

   int n_chk = 0, n_fail = 0, pf_seen = 0, base = 0;
   logic [LW-1:0] exp_q[$];
   logic [LW-1:0] out_q[$];
   logic [LW-1:0] mon_e;

   function automatic logic [LW-1:0] ln(int pg, int off);
      return {20'(pg), 6'(off)};
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(bit ov, logic [LW-1:0] ol, bit dv, logic [LW-1:0] dl,
                      bit cv, logic [LW-1:0] cl);
      @(posedge clk); #1;
      obs_valid = ov; obs_line = ol;
      dmd_alloc_valid = dv; dmd_alloc_line = dl;
      cmp_valid = cv; cmp_line = cl;
      if (dv) out_q.push_back(dl);
   endtask

   task automatic idle(int n);
      repeat (n) cyc(1'b0, '0, 1'b0, '0, 1'b0, '0);
   endtask

   task automatic obs(int pg, int off);
      cyc(1'b1, ln(pg, off), 1'b0, '0, 1'b0, '0);
   endtask

   task automatic dmd(logic [LW-1:0] l);
      cyc(1'b0, '0, 1'b1, l, 1'b0, '0);
   endtask

   task automatic drain();
      for (int r = 0; r < 20; r++) begin
         while (out_q.size() > 0) begin
            logic [LW-1:0] l;
            l = out_q.pop_front();
            cyc(1'b0, '0, 1'b0, '0, 1'b1, l);
         end
         idle(8);
         if (out_q.size() == 0) break;
      end
   endtask

   task automatic expect_done(string req);
      chk(exp_q.size() == 0, req, "prefetches still missing", exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && pf_valid) begin
         pf_seen++;
         out_q.push_back(pf_line);
         chk(!dmd_alloc_valid && !obs_valid, "R6", "prefetch beside demand or observe",
             int'(dmd_alloc_valid), 0);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected prefetch line", int'(pf_line), -1);
         end else begin
            mon_e = exp_q.pop_front();
            chk(pf_line == mon_e, "R3", "prefetch line", int'(pf_line), int'(mon_e));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: idle after reset
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(pf_valid == 1'b0, "R1", "pf_valid after reset", int'(pf_valid), 0);
      end

      // R3: ascending stride 2, window of 4 then extension by one
      exp_q.push_back(ln(1, 16)); exp_q.push_back(ln(1, 18));
      exp_q.push_back(ln(1, 20)); exp_q.push_back(ln(1, 22));
      obs(1, 10); obs(1, 12); obs(1, 14); idle(8);
      expect_done("R3");
      exp_q.push_back(ln(1, 24));
      obs(1, 16); idle(4);
      expect_done("R3");

      // R4: descending stream stops at offset 0
      exp_q.push_back(ln(2, 2)); exp_q.push_back(ln(2, 1)); exp_q.push_back(ln(2, 0));
      obs(2, 5); obs(2, 4); obs(2, 3); idle(8);
      expect_done("R4");

      // R4: first target beyond offset 63 issues nothing
      base = pf_seen;
      obs(3, 55); obs(3, 58); obs(3, 61); idle(8);
      chk(pf_seen == base, "R4", "prefetches past page end", pf_seen - base, 0);

      // R2: changing deltas never train; a single delta is not enough
      base = pf_seen;
      obs(4, 0); obs(4, 2); obs(4, 5); obs(4, 9); idle(8);
      chk(pf_seen == base, "R2", "prefetches on irregular deltas", pf_seen - base, 0);
      obs(13, 0); obs(13, 1); idle(6);
      chk(pf_seen == base, "R2", "prefetches after one delta", pf_seen - base, 0);
      drain();

      // R5 and R9: throttle at exactly 4 free entries, release by completion
      for (int k = 0; k < 12; k++) dmd(ln(100, k));
      exp_q.push_back(ln(5, 3)); exp_q.push_back(ln(5, 4));
      exp_q.push_back(ln(5, 5)); exp_q.push_back(ln(5, 6));
      base = pf_seen;
      obs(5, 0); obs(5, 1); obs(5, 2); idle(6);
      chk(pf_seen - base == 1, "R5", "prefetches with 4 then 3 free", pf_seen - base, 1);
      begin
         logic [LW-1:0] l;
         l = out_q.pop_front();
         cyc(1'b0, '0, 1'b0, '0, 1'b1, l);
      end
      idle(4);
      chk(pf_seen - base == 2, "R9", "prefetches after one completion", pf_seen - base, 2);
      drain();
      expect_done("R5");

      // R6: held-back prefetches while demand allocations run
      exp_q.push_back(ln(6, 3)); exp_q.push_back(ln(6, 4));
      exp_q.push_back(ln(6, 5)); exp_q.push_back(ln(6, 6));
      base = pf_seen;
      cyc(1'b1, ln(6, 0), 1'b1, ln(101, 0), 1'b0, '0);
      cyc(1'b1, ln(6, 1), 1'b1, ln(101, 1), 1'b0, '0);
      cyc(1'b1, ln(6, 2), 1'b1, ln(101, 2), 1'b0, '0);
      for (int k = 3; k < 9; k++) dmd(ln(101, k));
      chk(pf_seen == base, "R6", "prefetches during demand burst", pf_seen - base, 0);
      idle(6);
      expect_done("R6");
      drain();

      // R7: queued line is skipped but counts toward the window
      dmd(ln(7, 20));
      exp_q.push_back(ln(7, 22)); exp_q.push_back(ln(7, 24)); exp_q.push_back(ln(7, 26));
      obs(7, 14); obs(7, 16); obs(7, 18); idle(8);
      expect_done("R7");
      drain();

      // R8: least-recently-used page is evicted and retrains
      exp_q.push_back(ln(8, 3)); exp_q.push_back(ln(8, 4));
      exp_q.push_back(ln(8, 5)); exp_q.push_back(ln(8, 6));
      obs(8, 0); obs(8, 1); obs(8, 2); idle(8);
      expect_done("R8");
      base = pf_seen;
      obs(9, 0); obs(10, 0); obs(11, 0); obs(12, 0);
      obs(8, 3); obs(8, 4); idle(4);
      chk(pf_seen == base, "R8", "prefetches from evicted page", pf_seen - base, 0);
      exp_q.push_back(ln(8, 7)); exp_q.push_back(ln(8, 8)); exp_q.push_back(ln(8, 9));
      obs(8, 5); idle(8);
      expect_done("R8");
      drain();

      summary();
   end
endmodule